// File: doc/BRIEF.md
# Flash reset and power-state controller

This controller sits inside a parallel NOR-style memory device, between the external control pins and the internal engines. It qualifies the active-low hardware reset pin against a minimum pulse width. A qualified reset aborts any program or erase that is running, returns the command state machine to array-read mode and runs a recovery interval. During that interval the ready/busy pin stays low if an operation was cut short. Reads are allowed again only after a settling delay that starts when the reset pin rises.

The controller also reports two low-power states. Chip-deselect standby is entered when chip enable is inactive and the program/erase engine is idle. Automatic sleep is entered when the address bus has not changed for a set number of clock cycles. Sleep does not depend on the control strobes. While in sleep, the data-output enable is left untouched, so the last read data stays latched on the outputs. Every timing limit is a parameter counted in clock cycles.

Top module: `flash_rst_pwr_ctl`

## Requirements
- R1: When `rst_pin_n` is sampled low on T_RP consecutive clock edges, `csm_reset` goes high after the T_RP-th edge and stays high until the first edge that samples the pin high. A low pulse that covers fewer edges never raises `csm_reset`.
- R2: `pe_abort` is high for exactly one cycle, directly after the edge that qualifies a reset, and only if `pe_busy` was high at that edge. A filtered pulse or an idle engine gives no abort.
- R3: While `rst_pin_n` is low, `dout_en` and `read_ok` are both low, whatever the other pins do.
- R4: If the engine was busy when a reset qualified, `ry_by_n` stays low for T_READY cycles after the qualifying edge, even when the engine drops `pe_busy`. If the engine was idle, `ry_by_n` stays high during and after the reset.
- R5: `read_ok` goes high only after `rst_pin_n` has been sampled high on T_RH consecutive edges and the recovery interval of R4 has ended. This holds whether the pulse qualified or not.
- R6: `dout_en` is high exactly when `ce_n`=0, `oe_n`=0, `we_n`=1 and `read_ok`=1. With `ce_n`=1 the outputs are off whatever `oe_n` is.
- R7: `power_standby` is high exactly when `ce_n`=1 and `pe_busy`=0. A chip deselected during an operation stays active until `pe_busy` falls.
- R8: `sleep` goes high after the address bus has held one value for T_SLP+1 consecutive edges, counting the edge that first sees the new value. This does not depend on `ce_n`, `oe_n` and `we_n`, and it leaves `dout_en` unchanged.
- R9: A change of any single address bit clears `sleep` after the next clock edge and restarts the stability count.
- R10: Outside a qualified reset, `ry_by_n` is the inverse of `pe_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rst_pin_n | input | 1 | Hardware reset pin, active low |
| addr | input | AW | Address bus |
| pe_busy | input | 1 | Program/erase engine is running |
| ry_by_n | output | 1 | Ready (1) / busy (0) pin |
| dout_en | output | 1 | Drive the data outputs |
| pe_abort | output | 1 | One-cycle abort request to the program/erase engine |
| csm_reset | output | 1 | Returns the command state machine to array read |
| sleep | output | 1 | Automatic sleep state |
| power_standby | output | 1 | Chip-deselect standby state |
| read_ok | output | 1 | Array reads are allowed |

## Verification
Every reset pulse width from one edge up to three past the qualifying width is applied once with the engine idle and once with it busy. This separates filtered pulses from qualified ones, and busy recovery from idle recovery, and it times `read_ok` against both the release delay and the recovery interval. All sixteen combinations of `ce_n`, `oe_n`, `we_n` and `pe_busy` check the output enable, standby and ready/busy against simple formulas. For sleep, every hold length around the threshold is applied while the control strobes toggle. After that, each address bit is flipped on its own to show that one bit is enough to wake the block.

// File: rtl/flash_rst_pwr_ctl.sv
module flash_rst_pwr_ctl #(
  parameter int AW      = 8,
  parameter int T_RP    = 4,
  parameter int T_READY = 20,
  parameter int T_RH    = 3,
  parameter int T_SLP   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          rst_pin_n,
  input  logic [AW-1:0] addr,
  input  logic          pe_busy,
  output logic          ry_by_n,
  output logic          dout_en,
  output logic          pe_abort,
  output logic          csm_reset,
  output logic          sleep,
  output logic          power_standby,
  output logic          read_ok
);
  localparam int RPW = $clog2(T_RP + 1);
  localparam int RDW = $clog2(T_READY + 1);
  localparam int RHW = $clog2(T_RH + 1);
  localparam int SLW = $clog2(T_SLP + 1);

  logic [RPW-1:0] rp_cnt;
  logic [RDW-1:0] rec_cnt;
  logic [RHW-1:0] rh_cnt;
  logic [SLW-1:0] sl_cnt;
  logic [AW-1:0]  addr_q;
  logic           hold_busy;
  logic           abort_q;

  logic qual, qual_edge, addr_moved;
  assign qual       = (rp_cnt == RPW'(T_RP));
  assign qual_edge  = !rst_pin_n && (rp_cnt == RPW'(T_RP - 1));
  assign addr_moved = (addr != addr_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            rp_cnt <= '0;
    else if (rst_pin_n)    rp_cnt <= '0;
    else if (!qual)        rp_cnt <= rp_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rec_cnt   <= '0;
      hold_busy <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      abort_q <= qual_edge && pe_busy;
      if (qual_edge) begin
        rec_cnt   <= RDW'(T_READY);
        hold_busy <= pe_busy;
      end else if (rec_cnt != '0) begin
        rec_cnt <= rec_cnt - 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             rh_cnt <= '0;
    else if (!rst_pin_n)    rh_cnt <= RHW'(T_RH);
    else if (rh_cnt != '0)  rh_cnt <= rh_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0;
      sl_cnt <= '0;
    end else begin
      addr_q <= addr;
      if (addr_moved)                   sl_cnt <= '0;
      else if (sl_cnt != SLW'(T_SLP))   sl_cnt <= sl_cnt + 1'b1;
    end

  assign pe_abort      = abort_q;
  assign csm_reset     = qual;
  assign ry_by_n       = !((pe_busy && !qual) || (hold_busy && rec_cnt != '0));
  assign read_ok       = rst_pin_n && (rh_cnt == '0) && (rec_cnt == '0);
  assign dout_en       = read_ok && !ce_n && !oe_n && we_n;
  assign power_standby = ce_n && !pe_busy;
  assign sleep         = (sl_cnt == SLW'(T_SLP));
endmodule

module flash_rst_pwr_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          rst_pin_n,
  input logic [AW-1:0] addr,
  input logic          pe_busy,
  input logic          ry_by_n,
  input logic          dout_en,
  input logic          pe_abort,
  input logic          csm_reset,
  input logic          sleep,
  input logic          power_standby,
  input logic          read_ok
);
  // R2
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_abort |=> !pe_abort);
  // R2
  abort_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_abort |-> csm_reset);
  // R3
  pin_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin_n |-> (!dout_en && !read_ok));
  // R4
  abort_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_abort |-> !ry_by_n);
  // R6
  deselect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);
  // R7
  busy_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_busy |-> !power_standby);
  // R9
  addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |=> !sleep);
  // R5
  read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |-> rst_pin_n);
endmodule

bind flash_rst_pwr_ctl flash_rst_pwr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_pin_n(rst_pin_n),
  .addr(addr), .pe_busy(pe_busy), .ry_by_n(ry_by_n), .dout_en(dout_en),
  .pe_abort(pe_abort), .csm_reset(csm_reset), .sleep(sleep),
  .power_standby(power_standby), .read_ok(read_ok)
);

// File: tb/flash_rst_pwr_ctl_tb.sv
module flash_rst_pwr_ctl_tb;
  localparam int AW = 8, T_RP = 4, T_READY = 20, T_RH = 3, T_SLP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rst_pin_n = 1'b1, pe_busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ry_by_n, dout_en, pe_abort, csm_reset, sleep, power_standby, read_ok;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_rst_pwr_ctl #(.AW(AW), .T_RP(T_RP), .T_READY(T_READY), .T_RH(T_RH), .T_SLP(T_SLP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rst_pin_n(rst_pin_n), .addr(addr), .pe_busy(pe_busy), .ry_by_n(ry_by_n),
    .dout_en(dout_en), .pe_abort(pe_abort), .csm_reset(csm_reset), .sleep(sleep),
    .power_standby(power_standby), .read_ok(read_ok));

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog: got running expected finished");
    summary();
  end

  initial begin
    tick(); tick();
    chk("R1 reset state csm_reset", csm_reset, 1'b0);
    chk("R2 reset state pe_abort", pe_abort, 1'b0);
    chk("R8 reset state sleep", sleep, 1'b0);
    chk("R10 reset state ry_by_n", ry_by_n, 1'b1);
    rst_n = 1'b1;
    tick();

    // R1 R2 R3 R4 R5 R10: reset pulse width sweep, engine idle and busy
    for (int w = 1; w <= T_RP + 3; w++) begin
      for (int b = 0; b < 2; b++) begin
        bit q;
        q = (w >= T_RP);
        ce_n = 0; oe_n = 0; we_n = 1;
        pe_busy = 1'(b); rst_pin_n = 0;
        for (int t = 1; t <= w + T_READY + T_RH + 6; t++) begin
          int cnt, rec, rh;
          bit qual, busy_now, ry_e, rd_e;
          tick();
          cnt = (t <= w) ? ((t < T_RP) ? t : T_RP) : 0;
          qual = (cnt == T_RP);
          rec = (q && t >= T_RP && (T_READY - (t - T_RP)) > 0) ? T_READY - (t - T_RP) : 0;
          rh = (t <= w) ? T_RH : (((T_RH - (t - w)) > 0) ? T_RH - (t - w) : 0);
          busy_now = (b == 1) && !(q && t >= T_RP);
          ry_e = !((busy_now && !qual) || (b == 1 && rec != 0));
          rd_e = (t > w) && rh == 0 && rec == 0;
          chk("R1 csm_reset", csm_reset, qual);
          chk("R2 pe_abort", pe_abort, (b == 1) && q && t == T_RP);
          chk("R4 R10 ry_by_n", ry_by_n, ry_e);
          chk("R3 R5 read_ok", read_ok, rd_e);
          chk("R3 R6 dout_en", dout_en, rd_e);
          if (t == w) rst_pin_n = 1;
          if (b == 1 && q && t == T_RP) pe_busy = 0;
        end
        pe_busy = 0;
        tick(); tick();
      end
    end

    // R6 R7 R10: control pin combinations with reads allowed
    for (int v = 0; v < 16; v++) begin
      ce_n = v[0]; oe_n = v[1]; we_n = v[2]; pe_busy = v[3];
      tick();
      chk("R6 dout_en", dout_en, !v[0] && !v[1] && v[2]);
      chk("R7 power_standby", power_standby, v[0] && !v[3]);
      chk("R10 ry_by_n", ry_by_n, !v[3]);
    end
    pe_busy = 0; ce_n = 0; oe_n = 0; we_n = 1;

    // R8: hold lengths around the sleep threshold, strobes toggling
    for (int h = 1; h <= T_SLP + 3; h++) begin
      addr = addr + 8'h35;
      for (int j = 1; j <= h; j++) begin
        tick();
        chk("R8 sleep", sleep, j >= T_SLP + 1);
        chk("R8 dout_en kept in sleep", dout_en, !ce_n && !oe_n && we_n);
        ce_n = j[0]; oe_n = j[1]; we_n = !j[0];
      end
    end
    ce_n = 0; oe_n = 0; we_n = 1;

    // R9: each single address bit wakes the block
    for (int bit_i = 0; bit_i < AW; bit_i++) begin
      for (int j = 0; j <= T_SLP + 1; j++) tick();
      chk("R9 asleep before flip", sleep, 1'b1);
      addr[bit_i] = ~addr[bit_i];
      tick();
      chk("R9 sleep after bit flip", sleep, 1'b0);
    end

    summary();
  end
endmodule